// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a three-wire serial audio stream (bit clock, word clock, data) and rebuilds one left and one right parallel sample per frame. It runs entirely on the bit clock: the bit clock is its only clock, and the word clock and data are sampled on each rising edge. A frame is 64 bit clocks long, made of two 32-slot halves. A two-bit format input selects left-justified, I2S or right-justified framing. A two-bit width input selects 16, 18, 20 or 24-bit words.

A word-clock edge is found by comparing each new word-clock sample with the one before it. The slot index restarts at 0 on that edge. A window decoder turns the slot index into an active bit range for the selected format and width, and a shift register collects the bits inside that range, MSB first. A three-state controller keeps track of which half is being received. Its states are `ST_HUNT` (waiting for a frame start), `ST_LEFT` (left half) and `ST_RIGHT` (right half). Its transitions are:

- HUNT→LEFT on a frame boundary.
- LEFT→RIGHT on any word-clock edge.
- RIGHT→LEFT on a frame boundary.
- RIGHT→HUNT on an edge that is not a frame boundary.

A frame boundary is a word-clock edge, seen outside `ST_LEFT`, whose new level is the left-channel level of the format currently requested at the inputs. Format and width are loaded only at a frame boundary.

Top module: `serial_audio_rx`

## Requirements
- R1: The format input selects how the word clock and data are read. Code 0 is left-justified: word clock high means left, and the MSB is in slot 0. Code 1 is I2S: word clock low means left, and the MSB is in slot 1. Code 2 is right-justified: word clock high means left, and the LSB is in slot 31, so the MSB is in slot 32 minus the width. Code 3 behaves exactly like code 0. Slot 0 is the first rising bit-clock edge on which the new word-clock level is seen.
- R2: The width input selects the word length: code 0 gives 16 bits, code 1 gives 18, code 2 gives 20 and code 3 gives 24.
- R3: Each captured word appears right-aligned in its 24-bit output with all higher bits zero. Data bits in slots outside the active window have no effect on the outputs.
- R4: `left_sample` takes the new left word on the bit-clock edge that follows the left word's last bit. `right_sample` updates on the edge that follows the right word's last bit, and `sample_valid` pulses high for exactly one cycle on that same edge. There is one pulse per frame, and only when the left word of the same frame was captured.
- R5: A change on `fmt_sel` or `width_sel` does not affect the frame in progress. It takes effect at the next frame boundary.
- R6: No sample is captured and no valid pulse is issued until a frame boundary has been seen. This applies after reset, and after a change of word-clock polarity, where the frame during which the change happens produces no pulse. Slots beyond the 32nd without a word-clock edge never capture.
- R7: An active-low synchronous reset clears both sample outputs, the valid pulse, the slot counter and the shift register, and returns the controller to `ST_HUNT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; every register updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk | input | 1 | Word (frame) clock; its level marks the channel |
| sdata | input | 1 | Serial data, one bit per bit clock |
| fmt_sel | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 same as 0 |
| width_sel | input | 2 | Word length: 0=16, 1=18, 2=20, 3=24 bits |
| left_sample | output | SAMPLE_W | Last left word, right-aligned and zero-filled |
| right_sample | output | SAMPLE_W | Last right word, right-aligned and zero-filled |
| sample_valid | output | 1 | One-cycle pulse when a full left/right pair is ready |

## Verification
Count each frame from the rising edge of its slot 0, where slot 0 is at offset 0. On that count, the left word is due on the edge at offset start+W-1. The right word and the valid pulse are due one half later, at offset 32+start+W-1. Here start is 0, 1 or 32-W depending on the format. The bench keeps a cycle counter and records, on the falling edge, the counter value at which each output changed. It compares that value with the offset computed from the format and width, and with the same rule checks that a width change made mid-frame only shows in the following frame.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Framing codes as they appear on fmt_sel
    typedef enum logic [1:0] {
        FMT_LJ     = 2'd0,
        FMT_I2S    = 2'd1,
        FMT_RJ     = 2'd2,
        FMT_LJ_ALT = 2'd3
    } fmt_e;

    // Receiver controller states
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } rx_state_e;

    // Active configuration, loaded only at a frame boundary
    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wsel;
    } rx_cfg_t;

    // Word-clock level that marks the left channel
    function automatic logic left_level(input fmt_e f);
        return (f != FMT_I2S);
    endfunction

    // Word length in bits for a width code
    function automatic logic [4:0] word_len(input logic [1:0] ws);
        logic [4:0] len;
        unique case (ws)
            2'd0:    len = 5'd16;
            2'd1:    len = 5'd18;
            2'd2:    len = 5'd20;
            default: len = 5'd24;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/sar_wclk_track.sv
module sar_wclk_track #(
    parameter int HALF_SLOTS = 32,
    parameter int IDX_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk,
    output logic             wclk_edge,
    output logic [IDX_W-1:0] slot_idx
);

    // Saturating ceiling: a half that runs long never wraps back into a window
    localparam logic [IDX_W-1:0] SAT = IDX_W'(2 * HALF_SLOTS - 1);

    logic             wclk_q;
    logic [IDX_W-1:0] cnt_q;

    assign wclk_edge = wclk ^ wclk_q;

    // Slot index of the sample being taken on this edge
    always_comb begin
        if (wclk_edge) begin
            slot_idx = '0;
        end else if (cnt_q == SAT) begin
            slot_idx = SAT;
        end else begin
            slot_idx = cnt_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
            cnt_q  <= SAT;
        end else begin
            wclk_q <= wclk;
            cnt_q  <= slot_idx;
        end
    end

    // A half never longer than the saturation point restarts from zero
    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wclk_edge |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/sar_window.sv
module sar_window
    import sar_pkg::*;
#(
    parameter int HALF_SLOTS = 32,
    parameter int IDX_W      = 6
) (
    input  fmt_e             fmt,
    input  logic [1:0]       wsel,
    input  logic [IDX_W-1:0] slot_idx,
    output logic             in_win,
    output logic             first_bit,
    output logic             last_bit,
    output logic [4:0]       len_o
);

    localparam int EW = IDX_W + 1;
    localparam logic [EW-1:0] HALF_L = EW'(HALF_SLOTS);

    logic [EW-1:0] start_s;
    logic [EW-1:0] stop_s;
    logic [EW-1:0] idx_e;
    logic [EW-1:0] len_e;

    assign len_o = word_len(wsel);
    assign len_e = EW'(len_o);
    assign idx_e = EW'(slot_idx);

    // MSB slot per framing
    always_comb begin
        unique case (fmt)
            FMT_I2S: start_s = EW'(1);
            FMT_RJ:  start_s = HALF_L - len_e;
            default: start_s = '0;
        endcase
    end

    assign stop_s    = start_s + len_e - EW'(1);
    assign in_win    = (idx_e >= start_s) && (idx_e <= stop_s);
    assign first_bit = (idx_e == start_s);
    assign last_bit  = (idx_e == stop_s);

endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                restart,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] word_next
);

    logic [SAMPLE_W-1:0] sh_q;

    // A fresh word starts from zero, so shorter words stay zero-filled
    assign word_next = restart ? {{(SAMPLE_W-1){1'b0}}, sdata}
                               : {sh_q[SAMPLE_W-2:0], sdata};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= word_next;
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int HALF_SLOTS = 32
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                wclk,
    input  logic                sdata,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                sample_valid
);

    localparam int IDX_W = $clog2(2 * HALF_SLOTS);

    rx_state_e        state_q, state_d;
    rx_cfg_t          act_q, pend, eff;
    logic             wclk_edge;
    logic [IDX_W-1:0] slot_idx;
    logic             boundary;
    logic             in_win, first_bit, last_bit;
    logic [4:0]       len;
    logic [SAMPLE_W-1:0] word_next;
    logic             shift_en, take_left, take_right;
    logic [SAMPLE_W-1:0] left_q, right_q;
    logic             vld_q, left_done_q;

    assign pend.fmt  = fmt_e'(fmt_sel);
    assign pend.wsel = width_sel;

    // Frame boundary: edge into the requested format's left level
    assign boundary = wclk_edge && (wclk == left_level(pend.fmt)) && (state_q != ST_LEFT);
    assign eff      = boundary ? pend : act_q;

    sar_wclk_track #(
        .HALF_SLOTS (HALF_SLOTS),
        .IDX_W      (IDX_W)
    ) u_track (
        .clk        (bclk),
        .rst_n      (rst_n),
        .wclk       (wclk),
        .wclk_edge  (wclk_edge),
        .slot_idx   (slot_idx)
    );

    sar_window #(
        .HALF_SLOTS (HALF_SLOTS),
        .IDX_W      (IDX_W)
    ) u_window (
        .fmt        (eff.fmt),
        .wsel       (eff.wsel),
        .slot_idx   (slot_idx),
        .in_win     (in_win),
        .first_bit  (first_bit),
        .last_bit   (last_bit),
        .len_o      (len)
    );

    sar_shifter #(
        .SAMPLE_W   (SAMPLE_W)
    ) u_shift (
        .clk        (bclk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .restart    (first_bit),
        .sdata      (sdata),
        .word_next  (word_next)
    );

    // State register
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (boundary) state_d = ST_LEFT;
            end
            ST_LEFT: begin
                if (wclk_edge) state_d = ST_RIGHT;
            end
            ST_RIGHT: begin
                if (wclk_edge) state_d = boundary ? ST_LEFT : ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // Capture strobes follow the half the current sample belongs to
    assign shift_en   = (state_d != ST_HUNT) && in_win;
    assign take_left  = (state_d == ST_LEFT)  && in_win && last_bit;
    assign take_right = (state_d == ST_RIGHT) && in_win && last_bit;

    // Output registers
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            act_q       <= pend;
            left_q      <= '0;
            right_q     <= '0;
            vld_q       <= 1'b0;
            left_done_q <= 1'b0;
        end else begin
            if (boundary) begin
                act_q <= pend;
            end
            if (take_left) begin
                left_q <= word_next;
            end
            if (take_right) begin
                right_q <= word_next;
            end
            vld_q <= take_right && left_done_q;
            if (take_left) begin
                left_done_q <= 1'b1;
            end else if (boundary || take_right) begin
                left_done_q <= 1'b0;
            end
        end
    end

    assign left_sample  = left_q;
    assign right_sample = right_q;
    assign sample_valid = vld_q;

    AST_LEFT_LEVEL: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q == ST_LEFT && !wclk_edge) |-> (wclk == left_level(act_q.fmt))); // R1

    AST_ZERO_FILL: assert property (@(posedge bclk) disable iff (!rst_n)
        (take_left || take_right) |-> ((word_next >> len) == '0)); // R3

    AST_VLD_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
        sample_valid |=> !sample_valid); // R4

    AST_VLD_IN_RIGHT: assert property (@(posedge bclk) disable iff (!rst_n)
        sample_valid |-> (state_q == ST_RIGHT)); // R4

    AST_CFG_AT_FRAME: assert property (@(posedge bclk) disable iff (!rst_n)
        !boundary |=> $stable(act_q)); // R5

    AST_HUNT_QUIET: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q == ST_HUNT && !boundary) |=>
            ($stable(left_q) && $stable(right_q) && !sample_valid)); // R6

endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [1:0]  f;
        logic [1:0]  ws;
        logic [23:0] l;
        logic [23:0] r;
        logic        ex;
    } vec_t;

    // Stimulus table: format, width, left, right, pulse expected
    localparam vec_t VECS [10] = '{
        '{f:2'd0, ws:2'd0, l:24'hFFA5C3, r:24'h123C5A, ex:1'b1},
        '{f:2'd0, ws:2'd3, l:24'h9ABCDE, r:24'h123456, ex:1'b1},
        '{f:2'd2, ws:2'd0, l:24'h00F00F, r:24'hEE0FF0, ex:1'b1},
        '{f:2'd2, ws:2'd1, l:24'h02AAAA, r:24'hF15555, ex:1'b1},
        '{f:2'd2, ws:2'd2, l:24'h0F1234, r:24'h30ABCD, ex:1'b1},
        '{f:2'd2, ws:2'd3, l:24'hC0FFEE, r:24'h7E57ED, ex:1'b1},
        '{f:2'd3, ws:2'd2, l:24'h013579, r:24'h0ECA86, ex:1'b1},
        '{f:2'd1, ws:2'd0, l:24'h00BEEF, r:24'h001234, ex:1'b0},
        '{f:2'd1, ws:2'd1, l:24'h03C3C3, r:24'h014141, ex:1'b1},
        '{f:2'd1, ws:2'd3, l:24'h800001, r:24'h7FFFFE, ex:1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic [1:0]  wsel_i = 2'd0;
    logic [23:0] left_sample, right_sample;
    logic        sample_valid;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int c0 = 0;
    int lchg_c = -1;
    logic [23:0] prev_l = 24'h0;
    bit done = 1'b0;

    int npulse = 0;
    logic [23:0] cap_l [64];
    logic [23:0] cap_r [64];
    int          cap_c [64];

    int n_exp = 0;
    logic [23:0] exp_l [64];
    logic [23:0] exp_r [64];
    int          exp_c [64];
    string       exp_t [64];

    always #(CLK_P/2) clk = ~clk;

    serial_audio_rx u0 (
        .bclk         (clk),
        .rst_n        (rst_n),
        .wclk         (wclk),
        .sdata        (sdata),
        .fmt_sel      (fmt_i),
        .width_sel    (wsel_i),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .sample_valid (sample_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: outputs are read on the falling edge only
    always @(negedge clk) begin
        if (rst_n && sample_valid && npulse < 64) begin
            cap_l[npulse] = left_sample;
            cap_r[npulse] = right_sample;
            cap_c[npulse] = cyc;
            npulse++;
        end
        if (left_sample != prev_l) lchg_c = cyc;
        prev_l = left_sample;
    end

    function automatic int blen(input logic [1:0] ws);
        case (ws)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic int bstart(input logic [1:0] f, input int len);
        if (f == 2'd1) return 1;
        if (f == 2'd2) return 32 - len;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // One half: 32 slots at a fixed word-clock level; off-window slots carry ones
    task automatic send_half(input logic lvl, input logic [1:0] f, input logic [1:0] ws,
                             input logic [23:0] d);
        int len = blen(ws);
        int st = bstart(f, len);
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            wclk = lvl;
            sdata = (s >= st && s < st + len) ? d[len - 1 - (s - st)] : 1'b1;
        end
    endtask

    task automatic send_frame(input logic [1:0] f, input logic [1:0] ws,
                              input logic [23:0] l, input logic [23:0] r,
                              input bit expect_p, input bit chg, input logic [1:0] ws2,
                              input string tag);
        int len = blen(ws);
        int st = bstart(f, len);
        logic lv = (f != 2'd1);
        logic [23:0] mask = (24'h1 << len) - 24'h1;
        for (int h = 0; h < 2; h++) begin
            for (int s = 0; s < 32; s++) begin
                @(negedge clk);
                if (h == 0 && s == 0) begin
                    fmt_i = f;
                    wsel_i = ws;
                    c0 = cyc + 1;
                end
                if (chg && h == 0 && s == 16) wsel_i = ws2;
                wclk = (h == 0) ? lv : ~lv;
                sdata = (s >= st && s < st + len)
                        ? ((h == 0) ? l[len - 1 - (s - st)] : r[len - 1 - (s - st)])
                        : 1'b1;
            end
        end
        if (expect_p && n_exp < 64) begin
            exp_l[n_exp] = l & mask;
            exp_r[n_exp] = r & mask;
            exp_c[n_exp] = c0 + 32 + st + len - 1;
            exp_t[n_exp] = tag;
            n_exp++;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int saved_c0;
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7 reset left", left_sample, 24'h0);
        check("R7 reset right", right_sample, 24'h0);
        check("R7 reset valid", {23'h0, sample_valid}, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 formats, R2 widths, R3 masking and ignored slots
        foreach (VECS[i]) begin
            send_frame(VECS[i].f, VECS[i].ws, VECS[i].l, VECS[i].r, VECS[i].ex, 1'b0, 2'd0,
                       "R1/R2/R3 table");
        end
        // R6: frame after the polarity flip must leave right at previous value until next pulse
        // (covered by its missing entry in the expected list)

        // R5: width change mid-frame applies only from the next frame
        send_frame(2'd1, 2'd0, 24'h004321, 24'h00ABCD, 1'b1, 1'b1, 2'd3, "R5 mid-frame width");
        saved_c0 = c0;
        check_int("R4 left latch cycle", lchg_c, saved_c0 + 16);
        send_frame(2'd1, 2'd3, 24'hA5A5A5, 24'h5A5A5A, 1'b1, 1'b0, 2'd0, "R5 next frame width");

        // R7: reset in mid-stream
        @(negedge clk);
        rst_n = 1'b0;
        wclk = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 mid reset left", left_sample, 24'h0);
        check("R7 mid reset right", right_sample, 24'h0);
        check("R7 mid reset valid", {23'h0, sample_valid}, 24'h0);
        rst_n = 1'b1;

        // R6: a right half before any frame boundary is not captured
        send_half(1'b1, 2'd1, 2'd2, 24'h0FEDCB);
        @(negedge clk);
        check("R6 no capture before boundary", right_sample, 24'h0);
        check("R6 no left before boundary", left_sample, 24'h0);
        send_frame(2'd1, 2'd2, 24'h0CAFE1, 24'h0D00D2, 1'b1, 1'b0, 2'd0, "R6 first frame after reset");
        repeat (2) @(negedge clk);

        // R4: pulse count and per-pulse contents and timing
        check_int("R4 pulse count", npulse, n_exp);
        for (int k = 0; k < n_exp && k < npulse; k++) begin
            check({exp_t[k], " left"}, cap_l[k], exp_l[k]);
            check({exp_t[k], " right"}, cap_r[k], exp_r[k]);
            check_int({exp_t[k], " R4 pulse cycle"}, cap_c[k], exp_c[k]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule